// File: doc/BRIEF.md
# Delayed Redundant-Core Output Comparator

This block guards a processor core against single faults by running a second copy of the core a fixed number of cycles behind it. The block holds both delay lines. One carries the system-side input bundle to the shadow copy late by `OFFSET` cycles. The other holds back the main core's output bundle by the same amount. With both delays equal, the two bundles that reach the comparator come from the same logical cycle. Once the comparison is armed, the block checks the delayed main bundle against the shadow bundle every cycle. Any difference in a protected bit sets a major alert.

The comparison stays off after reset until the delay lines have filled, so the zeros left in them by reset cannot look like a fault. A constant mask leaves some output bits out of the check, such as the core's own alert lines. The alert is sticky and clears only on reset. Static configuration (hart identity, boot address and similar) goes straight to the shadow copy with no delay and no protection. Both cores are outside the block and appear only as plain vectors.

Top module: `lockstep_cmp`

## Requirements
- R1: `shadowIn` shows the value that `sysIn` had `OFFSET` clock edges earlier. The delay registers reset to zero, so for the first `OFFSET` cycles after reset `shadowIn` reads zero.
- R2: `shadowCfg` follows `cfgIn` in the same cycle, with no register in between.
- R3: The comparison arms at the `OFFSET`-th rising edge after reset is released. A mismatch present before that edge never raises `alertMajor`. A mismatch in the cycle right after that edge does raise it.
- R4: When the comparison is armed, a single-bit difference on any compared bit of `shadowOut` raises `alertMajor` at the next rising edge.
- R5: When the comparison is armed, a single-cycle bit flip on any compared bit of `mainOut` raises `alertMajor` at the `OFFSET+1`-th rising edge after the flipped value is sampled. The alert stays low before that edge. Both R4 and R5 fall well inside `10 + OFFSET` cycles.
- R6: A bit that is 0 in `CMP_MASK` is never compared. With the default mask, bits 11 and 10 (the cores' own alert outputs) can differ on either core with no alert.
- R7: Once `alertMajor` is 1, it stays 1 until reset, even after the two cores agree again.
- R8: When both cores produce matching outputs, `alertMajor` stays 0 for the whole run.
- R9: Reset (`rstN` low) clears `alertMajor` and both delay lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sysIn | input | IN_W | Input bundle fed to the main core this cycle |
| cfgIn | input | CFG_W | Static configuration, not protected |
| mainOut | input | OUT_W | Output bundle of the main core |
| shadowOut | input | OUT_W | Output bundle of the shadow core |
| shadowIn | output | IN_W | Delayed input bundle for the shadow core |
| shadowCfg | output | CFG_W | Configuration passed straight to the shadow core |
| alertMajor | output | 1 | Sticky major alert on a mismatch |

## Verification
The assertions check these properties on every cycle:
- each delay stage takes the previous stage's value;
- the arming counter never passes `OFFSET`, and arming happens only at that count and then holds;
- nothing raises the alert while the comparison is disarmed;
- an armed mismatch always sets the alert;
- the alert never falls outside reset.

Some behaviours only the bench's scenarios can show:
- the exact alert latency for a flip on each side;
- which bit positions the mask leaves out;
- that warm-up mismatches are ignored;
- the end-to-end delay from `sysIn` to `shadowIn`.

The bench sweeps every output bit on both cores for these.

// File: rtl/lockstep_cmp_pkg.sv
package lockstep_cmp_pkg;
  // strobes from the control module to the datapath
  typedef struct packed {
    logic cmpEn;
  } strobe_t;
endpackage

// File: rtl/ls_delay.sv
module ls_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [DEPTH];
  logic pastValid;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg[0] <= '0;
        else       stg[0] <= d;
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg[i] <= '0;
        else       stg[i] <= stg[i-1];
      end
      // R1
      shift_order_chk: assert property (@(posedge clk) disable iff (!rstN)
        pastValid |-> stg[i] == $past(stg[i-1]));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  assign q = stg[DEPTH-1];
endmodule

// File: rtl/ls_ctrl.sv
module ls_ctrl
  import lockstep_cmp_pkg::*;
#(
  parameter int OFFSET = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    diffAny,
  output strobe_t strobe,
  output logic    alertQ
);
  localparam int CW = $clog2(OFFSET + 1);
  localparam logic [CW-1:0] CntTop  = CW'(OFFSET);
  localparam logic [CW-1:0] CntLast = CW'(OFFSET - 1);

  logic [CW-1:0] fillCnt;
  logic          cmpEnQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCnt <= '0;
      cmpEnQ  <= 1'b0;
    end else begin
      if (fillCnt != CntTop) fillCnt <= fillCnt + CW'(1);
      if (fillCnt == CntLast) cmpEnQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                alertQ <= 1'b0;
    else if (cmpEnQ && diffAny) alertQ <= 1'b1;
  end

  assign strobe.cmpEn = cmpEnQ;

  // R3
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillCnt <= CntTop);
  // R3
  arm_point_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmpEnQ) |-> fillCnt == CntTop);
  // R3
  arm_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmpEnQ |=> cmpEnQ);
  // R3
  quiet_warmup_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cmpEnQ && !alertQ) |=> !alertQ);
  // R4
  mismatch_alert_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmpEnQ && diffAny) |=> alertQ);
  // R7
  alert_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    alertQ |=> alertQ);
endmodule

// File: rtl/ls_data.sv
module ls_data
  import lockstep_cmp_pkg::*;
#(
  parameter int IN_W   = 8,
  parameter int OUT_W  = 12,
  parameter int OFFSET = 3,
  parameter logic [OUT_W-1:0] CMP_MASK = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [IN_W-1:0]  sysIn,
  input  logic [OUT_W-1:0] mainOut,
  input  logic [OUT_W-1:0] shadowOut,
  output logic [IN_W-1:0]  shadowIn,
  output logic             diffAny
);
  logic [OUT_W-1:0] mainDly;
  logic [OUT_W-1:0] diffBits;

  ls_delay #(.W(IN_W), .DEPTH(OFFSET)) u_inDly (
    .clk(clk), .rstN(rstN), .d(sysIn), .q(shadowIn)
  );

  ls_delay #(.W(OUT_W), .DEPTH(OFFSET)) u_outDly (
    .clk(clk), .rstN(rstN), .d(mainOut), .q(mainDly)
  );

  for (genvar b = 0; b < OUT_W; b++) begin : g_cmp
    if (CMP_MASK[b]) begin : g_on
      assign diffBits[b] = mainDly[b] ^ shadowOut[b];
    end else begin : g_off
      assign diffBits[b] = 1'b0;
    end
  end

  assign diffAny = |diffBits;

  // R6
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((mainDly ^ shadowOut) & CMP_MASK) == '0 |-> !diffAny);

  logic unusedStrobe;
  assign unusedStrobe = strobe.cmpEn;
endmodule

// File: rtl/lockstep_cmp.sv
module lockstep_cmp
  import lockstep_cmp_pkg::*;
#(
  parameter int IN_W   = 8,
  parameter int OUT_W  = 12,
  parameter int CFG_W  = 8,
  parameter int OFFSET = 3,
  parameter logic [OUT_W-1:0] CMP_MASK = {2'b00, {(OUT_W-2){1'b1}}}
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IN_W-1:0]  sysIn,
  input  logic [CFG_W-1:0] cfgIn,
  input  logic [OUT_W-1:0] mainOut,
  input  logic [OUT_W-1:0] shadowOut,
  output logic [IN_W-1:0]  shadowIn,
  output logic [CFG_W-1:0] shadowCfg,
  output logic             alertMajor
);
  strobe_t strobe;
  logic    diffAny;

  ls_ctrl #(.OFFSET(OFFSET)) u_ctrl (
    .clk(clk), .rstN(rstN), .diffAny(diffAny), .strobe(strobe), .alertQ(alertMajor)
  );

  ls_data #(.IN_W(IN_W), .OUT_W(OUT_W), .OFFSET(OFFSET), .CMP_MASK(CMP_MASK)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sysIn(sysIn), .mainOut(mainOut),
    .shadowOut(shadowOut), .shadowIn(shadowIn), .diffAny(diffAny)
  );

  // R2: configuration is static and left unprotected
  assign shadowCfg = cfgIn;

  // R9
  reset_clear_chk: assert property (@(posedge clk) !rstN |-> !alertMajor);
endmodule

// File: tb/sim_lockstep_cmp.sv
module sim_lockstep_cmp;
  localparam int OFF = 3;
  localparam int IW = 8, OW = 12, CW = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic [IW-1:0] sysIn = '0;
  logic [CW-1:0] cfgIn = '0;
  logic [OW-1:0] mainOut, shadowOut, injM = '0, injS = '0;
  logic [IW-1:0] shadowIn;
  logic [CW-1:0] shadowCfg;
  logic alertMajor;
  int errors = 0, checks = 0, cyc = 0;
  logic sAlert;
  logic [IW-1:0] sShadow;
  logic [IW-1:0] hist [64];

  always #10 clk = ~clk;

  function automatic logic [OW-1:0] core(input logic [IW-1:0] x);
    return {x[1:0], x ^ 8'hA5, x[7:6]};
  endfunction

  assign mainOut   = core(sysIn) ^ injM;
  assign shadowOut = core(shadowIn) ^ injS;

  lockstep_cmp #(.IN_W(IW), .OUT_W(OW), .CFG_W(CW), .OFFSET(OFF)) u0 (
    .clk(clk), .rstN(rstN), .sysIn(sysIn), .cfgIn(cfgIn), .mainOut(mainOut),
    .shadowOut(shadowOut), .shadowIn(shadowIn), .shadowCfg(shadowCfg),
    .alertMajor(alertMajor)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // sample at negedge, then drive a new pattern value
  task automatic step(input int k);
    @(negedge clk);
    sAlert = alertMajor;
    sShadow = shadowIn;
    sysIn = IW'(k * 37 + 5);
    hist[k % 64] = sysIn;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rstN = 1'b0; injM = '0; injS = '0; sysIn = 8'h3C;
    @(negedge clk);
    chk(alertMajor == 1'b0, "R9", alertMajor, 0);
    chk(shadowIn == '0, "R9", shadowIn, 0);
    @(negedge clk);
    rstN = 1'b1;
    sysIn = IW'(5);
    hist[0] = sysIn;
  endtask

  initial begin
    bit quiet;
    // R1, R3, R8: delay line and quiet warm-up with injected shadow flips
    do_reset();
    quiet = 1'b1;
    for (int k = 1; k < 40; k++) begin
      step(k);
      if (k < OFF) chk(sShadow == '0, "R1", sShadow, 0);
      else chk(sShadow == hist[(k - OFF) % 64], "R1", sShadow, hist[(k - OFF) % 64]);
      if (sAlert) quiet = 1'b0;
      injS = (k < OFF) ? OW'(1) << k : '0;
    end
    chk(quiet, "R3", !quiet, 0);
    chk(quiet, "R8", !quiet, 0);

    // R2: straight pass of configuration
    for (int v = 0; v < 256; v += 17) begin
      cfgIn = CW'(v);
      #1;
      chk(shadowCfg == CW'(v), "R2", shadowCfg, v);
    end

    // R3: shadow flip in the last warm-up cycle is ignored
    do_reset();
    quiet = 1'b1;
    for (int k = 1; k < 20; k++) begin
      step(k);
      if (sAlert) quiet = 1'b0;
      injS = (k == OFF - 1) ? OW'(1) : '0;
    end
    chk(quiet, "R3", !quiet, 0);

    // R3: shadow flip in the first armed cycle is caught
    do_reset();
    for (int k = 1; k <= OFF + 1; k++) begin
      step(k);
      if (k == OFF + 1) chk(sAlert == 1'b1, "R3", sAlert, 1);
      else chk(sAlert == 1'b0, "R3", sAlert, 0);
      injS = (k == OFF) ? OW'(1) << 4 : '0;
    end

    // R4 R5 R6 R7: every bit on both cores
    for (int side = 0; side < 2; side++) begin
      for (int b = 0; b < OW; b++) begin
        int lat;
        do_reset();
        for (int k = 1; k <= OFF + 2; k++) step(k);
        chk(sAlert == 1'b0, "R8", sAlert, 0);
        if (side == 0) injM = OW'(1) << b; else injS = OW'(1) << b;
        lat = (side == 0) ? OFF + 1 : 1;
        for (int n = 1; n <= 12 + OFF; n++) begin
          step(OFF + 2 + n);
          injM = '0; injS = '0;
          if (b >= OW - 2) chk(sAlert == 1'b0, "R6", sAlert, 0);
          else if (n < lat) chk(sAlert == 1'b0, side ? "R4" : "R5", sAlert, 0);
          else if (n == lat) chk(sAlert == 1'b1, side ? "R4" : "R5", sAlert, 1);
          else chk(sAlert == 1'b1, "R7", sAlert, 1);
        end
      end
    end

    // R9: reset clears the sticky alert
    do_reset();
    step(1);
    chk(sAlert == 1'b0, "R9", sAlert, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule